// File: doc/BRIEF.md
# Bus Clock Enable Divider Tree

This block turns one system clock into a set of single-cycle clock-enable strobes for a tiered bus fabric. A first divider derives the high-speed bus rate from the system clock. Three further dividers each derive a peripheral bus rate from that high-speed rate, so every peripheral bus strobe lands on a cycle where the high-speed strobe is also high. Downstream logic runs on the system clock and advances only on cycles where its strobe is asserted. The block produces no gated or divided clock.

The high-speed divider takes a 4-bit code. The divide-by-32 step is missing from its codes: the ratio goes from 16 straight to 64. Each peripheral divider takes a 3-bit code. A code change never cuts the current period short. The new ratio is loaded only when the running period ends. Six disable inputs mask the qualified strobe of one bus each: three high-speed bus ports and three peripheral buses. The shared counters are unaffected by these inputs, so a bus that is enabled again is already in phase.

Top module: `bus_ck_tree`

## Requirements
- R1: While `rst` is high, every divider is set to ratio 1 with its count cleared. On the first cycle after `rst` falls, `ahb_stb` and all three `apb_stb` bits are 1.
- R2: With `ahb_code` equal to 8, 9, 10 or 11, `ahb_stb` is high once every 2, 4, 8 or 16 system-clock cycles respectively.
- R3: With `ahb_code` equal to 12, 13, 14 or 15, `ahb_stb` is high once every 64, 128, 256 or 512 cycles. No code gives a ratio of 32.
- R4: With `ahb_code` below 8, `ahb_stb` is high on every cycle.
- R5: The field `apb_code[3*i+2:3*i]` sets the ratio of bus i. Values 4, 5, 6 and 7 make `apb_stb[i]` high on every 2nd, 4th, 8th or 16th cycle on which `ahb_stb` is high. Values below 4 make it high on every cycle on which `ahb_stb` is high.
- R6: An `apb_stb` bit is never high on a cycle where `ahb_stb` is low.
- R7: The three peripheral dividers count independently. Each follows only its own code field, and all three count the same `ahb_stb` pulses.
- R8: A code change takes effect only after the next strobe of the ratio already running. The period in progress keeps its old length, and the period after that strobe has the new length.
- R9: `ahb_en[j]` equals `ahb_stb` AND NOT `ahb_off[j]`. Bit 0 is the first high-speed bus port, bit 1 the second and bit 2 the fourth.
- R10: `apb_en[i]` equals `apb_stb[i]` AND NOT `apb_off[i]`. Bit i is peripheral bus i+1.
- R11: The disable inputs have no effect on `ahb_stb`, on `apb_stb`, or on the phase of any divider. A bus that is enabled again strobes on the same cycles as if it had never been disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ahb_code | input | 4 | High-speed bus divider code |
| apb_code | input | 9 | Three 3-bit peripheral divider codes; bus i uses bits 3i+2..3i |
| ahb_off | input | 3 | Disable bits for high-speed bus ports 1, 2 and 4 |
| apb_off | input | 3 | Disable bits for peripheral buses 1, 2 and 3 |
| ahb_stb | output | 1 | Raw high-speed bus strobe |
| apb_stb | output | 3 | Raw peripheral bus strobes |
| ahb_en | output | 3 | Qualified high-speed bus port strobes |
| apb_en | output | 3 | Qualified peripheral bus strobes |

## Verification
A wrong divider count or a wrong loaded ratio shows at the ports as a strobe on the wrong cycle. This shows up within one period of the ratio involved: at most 512 cycles for the high-speed divider, and at most 16 high-speed strobes for a peripheral divider. A ratio loaded at the wrong moment shows as one period of the wrong length, directly after a code change. A disable input that reaches a counter shows as a raw strobe out of step with the reference, one period after the bus is masked. Because outputs are compared with a cycle-accurate model on every clock, each of these faults is caught on the first cycle that differs.

// File: rtl/bus_ck_pkg.sv
package bus_ck_pkg;

    localparam int AHB_CODE_W = 4;
    localparam int APB_CODE_W = 3;
    localparam int SHIFT_W    = 4;
    localparam int CNT_W      = 9;   // enough for the largest ratio, 2**9
    localparam int N_AHB      = 3;
    localparam int N_APB      = 3;

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [SHIFT_W-1:0] act;
    } div_state_t;

    // log2 of the high-speed ratio; the step to 32 is skipped
    function automatic logic [SHIFT_W-1:0] ahb_shift(input logic [AHB_CODE_W-1:0] c);
        logic [SHIFT_W-1:0] low;
        low = SHIFT_W'(c[1:0]);
        if (!c[3])      return '0;
        else if (!c[2]) return low + SHIFT_W'(1);
        else            return low + SHIFT_W'(6);
    endfunction

    // log2 of a peripheral ratio relative to the high-speed strobe
    function automatic logic [SHIFT_W-1:0] apb_shift(input logic [APB_CODE_W-1:0] c);
        if (!c[2]) return '0;
        else       return SHIFT_W'(c[1:0]) + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/bus_ck_div.sv
module bus_ck_div
    import bus_ck_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [SHIFT_W-1:0] shift_req,
    output logic               stb
);
    div_state_t       st;
    logic [CNT_W-1:0] term;
    logic             at_term;

    always_comb begin
        term    = ~({CNT_W{1'b1}} << st.act);
        at_term = (st.cnt == term);
        stb     = tick & at_term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st.cnt <= '0;
            st.act <= '0;
        end else if (tick) begin
            if (at_term) begin
                st.cnt <= '0;
                st.act <= shift_req;
            end else begin
                st.cnt <= st.cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bus_ck_gate.sv
module bus_ck_gate #(
    parameter int N = 3
) (
    input  logic         stb,
    input  logic [N-1:0] off,
    output logic [N-1:0] en
);
    for (genvar k = 0; k < N; k++) begin : g_q
        assign en[k] = stb & ~off[k];
    end
endmodule

// File: rtl/bus_ck_tree.sv
module bus_ck_tree
    import bus_ck_pkg::*;
#(
    parameter int NA = N_AHB,
    parameter int NP = N_APB
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [AHB_CODE_W-1:0]    ahb_code,
    input  logic [NP*APB_CODE_W-1:0] apb_code,
    input  logic [NA-1:0]            ahb_off,
    input  logic [NP-1:0]            apb_off,
    output logic                     ahb_stb,
    output logic [NP-1:0]            apb_stb,
    output logic [NA-1:0]            ahb_en,
    output logic [NP-1:0]            apb_en
);
    bus_ck_div u_hdiv (
        .clk       (clk),
        .rst       (rst),
        .tick      (1'b1),
        .shift_req (ahb_shift(ahb_code)),
        .stb       (ahb_stb)
    );

    bus_ck_gate #(.N(NA)) u_hgate (
        .stb (ahb_stb),
        .off (ahb_off),
        .en  (ahb_en)
    );

    for (genvar i = 0; i < NP; i++) begin : g_p
        bus_ck_div u_pdiv (
            .clk       (clk),
            .rst       (rst),
            .tick      (ahb_stb),
            .shift_req (apb_shift(apb_code[i*APB_CODE_W +: APB_CODE_W])),
            .stb       (apb_stb[i])
        );

        bus_ck_gate #(.N(1)) u_pgate (
            .stb (apb_stb[i]),
            .off (apb_off[i]),
            .en  (apb_en[i])
        );
    end

endmodule

// File: rtl/bus_ck_tree_chk.sv
module bus_ck_tree_chk
    import bus_ck_pkg::*;
#(
    parameter int NA = N_AHB,
    parameter int NP = N_APB
) (
    input logic                     clk,
    input logic                     rst,
    input logic [AHB_CODE_W-1:0]    ahb_code,
    input logic [NP*APB_CODE_W-1:0] apb_code,
    input logic [NA-1:0]            ahb_off,
    input logic [NP-1:0]            apb_off,
    input logic                     ahb_stb,
    input logic [NP-1:0]            apb_stb,
    input logic [NA-1:0]            ahb_en,
    input logic [NP-1:0]            apb_en
);
    a_r6_apb_on_ahb_edge: assert property (@(posedge clk) disable iff (rst)
        (|apb_stb) |-> ahb_stb);

    a_r4_div1_every_cycle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ahb_stb) && !$past(ahb_code[AHB_CODE_W-1])) |-> ahb_stb);

    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ahb_stb) && $past(ahb_code[AHB_CODE_W-1])) |-> !ahb_stb);

    for (genvar j = 0; j < NA; j++) begin : g_h
        a_r9_en_needs_stb: assert property (@(posedge clk) disable iff (rst)
            ahb_en[j] |-> ahb_stb);
        a_r9_off_blocks: assert property (@(posedge clk) disable iff (rst)
            ahb_off[j] |-> !ahb_en[j]);
    end

    for (genvar i = 0; i < NP; i++) begin : g_p
        a_r10_en_needs_stb: assert property (@(posedge clk) disable iff (rst)
            apb_en[i] |-> apb_stb[i]);
        a_r10_off_blocks: assert property (@(posedge clk) disable iff (rst)
            apb_off[i] |-> !apb_en[i]);
        a_r5_apb_gap: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(apb_stb[i]) && $past(apb_code[i*APB_CODE_W + APB_CODE_W-1]))
            |-> !apb_stb[i]);
    end

endmodule

bind bus_ck_tree bus_ck_tree_chk #(.NA(NA), .NP(NP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ahb_code (ahb_code),
    .apb_code (apb_code),
    .ahb_off  (ahb_off),
    .apb_off  (apb_off),
    .ahb_stb  (ahb_stb),
    .apb_stb  (apb_stb),
    .ahb_en   (ahb_en),
    .apb_en   (apb_en)
);

// File: tb/bus_ck_tree_bench.sv
`timescale 1ns/1ps
module bus_ck_tree_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ahb_code = '0;
    logic [8:0] apb_code = '0;
    logic [2:0] ahb_off = '0;
    logic [2:0] apb_off = '0;
    logic       ahb_stb;
    logic [2:0] apb_stb;
    logic [2:0] ahb_en;
    logic [2:0] apb_en;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #10 clk = ~clk;   // 50 MHz

    bus_ck_tree u_bus_ck_tree (
        .clk      (clk),
        .rst      (rst),
        .ahb_code (ahb_code),
        .apb_code (apb_code),
        .ahb_off  (ahb_off),
        .apb_off  (apb_off),
        .ahb_stb  (ahb_stb),
        .apb_stb  (apb_stb),
        .ahb_en   (ahb_en),
        .apb_en   (apb_en)
    );

    function automatic int hs_ratio(input int c);
        case (c)
            8: return 2;    9: return 4;    10: return 8;   11: return 16;
            12: return 64;  13: return 128; 14: return 256; 15: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int ps_ratio(input int c);
        case (c)
            4: return 2; 5: return 4; 6: return 8; 7: return 16;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: cycles since last strobe and the ratio in force
    int m_h_cnt, m_h_rat;
    int m_p_cnt[3];
    int m_p_rat[3];

    always @(negedge clk) begin
        if (rst) begin
            m_h_cnt = 0; m_h_rat = 1;
            for (int i = 0; i < 3; i++) begin m_p_cnt[i] = 0; m_p_rat[i] = 1; end
        end else if (!done) begin
            bit e_h;
            bit e_p[3];
            e_h = (m_h_cnt == m_h_rat - 1);
            chk(ahb_stb == e_h, "R2 R3 R4 R8 ahb_stb", ahb_stb, e_h);
            for (int j = 0; j < 3; j++)
                chk(ahb_en[j] == (e_h && !ahb_off[j]), "R9 R11 ahb_en", ahb_en[j], e_h && !ahb_off[j]);
            for (int i = 0; i < 3; i++) begin
                e_p[i] = e_h && (m_p_cnt[i] == m_p_rat[i] - 1);
                chk(apb_stb[i] == e_p[i], "R5 R6 R7 R8 apb_stb", apb_stb[i], e_p[i]);
                chk(apb_en[i] == (e_p[i] && !apb_off[i]), "R10 R11 apb_en", apb_en[i], e_p[i] && !apb_off[i]);
            end
            if (e_h) begin
                for (int i = 0; i < 3; i++) begin
                    if (e_p[i]) begin
                        m_p_cnt[i] = 0;
                        m_p_rat[i] = ps_ratio(int'(apb_code[i*3 +: 3]));
                    end else m_p_cnt[i]++;
                end
                m_h_cnt = 0;
                m_h_rat = hs_ratio(int'(ahb_code));
            end else m_h_cnt++;
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_h();
        do @(negedge clk); while (!ahb_stb);
    endtask

    task automatic count_h(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!ahb_stb);
    endtask

    task automatic wait_p(input int i);
        do @(negedge clk); while (!apb_stb[i]);
    endtask

    task automatic count_p(input int i, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!apb_stb[i]);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (4) step();
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle after reset, all raw strobes high
        chk(ahb_stb == 1'b1, "R1 ahb_stb after reset", ahb_stb, 1);
        chk(apb_stb == 3'b111, "R1 apb_stb after reset", apb_stb, 7);
        repeat (8) step();

        // R2 R3 R4: every high-speed code
        for (int c = 0; c < 16; c++) begin
            step(); ahb_code = 4'(c);
            wait_h();
            count_h(n);
            chk(n == hs_ratio(c), (c < 8) ? "R4 ahb period" : (c < 12) ? "R2 ahb period" : "R3 ahb period",
                n, hs_ratio(c));
        end

        // R5: every peripheral code on each bus, high-speed ratio 2
        step(); ahb_code = 4'd8;
        for (int i = 0; i < 3; i++) begin
            for (int c = 0; c < 8; c++) begin
                step(); apb_code[i*3 +: 3] = 3'(c);
                wait_p(i);
                count_p(i, n);
                chk(n == 2 * ps_ratio(c), "R5 apb period", n, 2 * ps_ratio(c));
            end
        end

        // R7: distinct codes at once
        step(); ahb_code = 4'd9; apb_code = {3'd7, 3'd5, 3'd4};
        repeat (400) step();

        // R8: change mid-period keeps the running period
        step(); ahb_code = 4'd15;
        wait_h(); wait_h();
        n = 0;
        repeat (100) begin @(negedge clk); n++; end
        step(); ahb_code = 4'd8;
        do begin @(negedge clk); n++; end while (!ahb_stb);
        chk(n == 512, "R8 old period kept", n, 512);
        count_h(n);
        chk(n == 2, "R8 new period", n, 2);

        // R9 R10 R11: disables toggled while dividers run
        step(); ahb_code = 4'd9; apb_code = {3'd6, 3'd5, 3'd4};
        for (int k = 0; k < 2000; k++) begin
            step();
            ahb_off = 3'($urandom);
            apb_off = 3'($urandom);
        end
        step(); ahb_off = '0; apb_off = '0;
        repeat (200) step();

        // mixed random segments
        for (int s = 0; s < 12; s++) begin
            step();
            ahb_code = 4'($urandom_range(0, 12));
            apb_code = 9'($urandom);
            for (int k = 0; k < 500; k++) begin
                step();
                if ((k % 7) == 0) begin
                    ahb_off = 3'($urandom);
                    apb_off = 3'($urandom);
                end
            end
        end

        done = 1;
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule